// File: doc/BRIEF.md
# Multiprocessor External Interrupt Distributor

This block takes a set of level-sensitive external interrupt sources and fans each one out to any subset of up to 32 processor cores. Each source has its own routing word: bit c of that word delivers the source to core c. A global per-source enable gates the external level. A software-assert mask raises a source no matter what its level or enable is. Each core receives its own vector of interrupt lines. The three lowest lines of that vector carry a per-core inter-processor interrupt value, which a separate unit produces and which enters here as an input.

Software reaches the block through a simple synchronous register port. A request carries the index of the core that issues it. The index is used by the identification register and by a per-core private control bit. The block also holds a run-stall register with one bit per core, and each bit drives that core's stall output directly.

Top module: `irqdist_top`

## Requirements
- R1: After reset: every source is enabled, and the software-assert mask is all zero. Every routing word reads 1, so only core 0 is routed. Run-stall is all ones except bit 0. Every private control bit is 0, and every core interrupt output is 0 while the IPI inputs are 0.
- R2: Source k is active when (level_k AND enable_k) OR assert_k is true. Core c's output line k+2 is the OR of (active_k AND route_k[c]) with that core's IPI bit on that line. The output is registered, so it updates on the first clock edge after an input change, and on the second clock edge after a register write.
- R3: A write to offset 0x180 clears each enable bit that is written as 1. A write to offset 0x184 sets each enable bit that is written as 1. Reading 0x180 returns the enable mask.
- R4: A write to 0x188 clears each software-assert bit that is written as 1. A write to 0x18C sets each software-assert bit that is written as 1. Reading 0x188 returns the mask. An asserted source is delivered even when its enable bit is 0.
- R5: The routing word of source k sits at offset k, for k from 0 to NUM_SRC-1. It holds NUM_CORES bits, taken from the low bits of the write data, and a read returns them zero-extended.
- R6: Source 0 has no external pin. External pin j (ext_irq[j]) feeds source j+1, so source 0 can be raised only by a software assert.
- R7: Core c's 3-bit IPI input, ipi_in[3c+2:3c], is ORed into that core's output lines 0 to 2.
- R8: A read of 0x1A0 returns ((NUM_CORES-1) << 18) OR the index of the requesting core.
- R9: A write to 0x200 loads the run-stall register, one bit per core. Stall output c equals bit c from the clock edge of the write onward, and a read of 0x200 returns the register.
- R10: Offset 0x220 holds a private control bit for each core. A write stores bit 0 of the data into the requesting core's bit. A read returns the requesting core's bit in bit 0 and zeros in all other bits.
- R11: A read of any other offset returns 0, and this includes the set addresses 0x184 and 0x18C. A write to any other offset changes no register and no output.
- R12: Read data appears on reg_rdata in the cycle after the read request. In any cycle after a clock edge that saw no read, reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | NUM_SRC-1 | External interrupt levels; bit j feeds source j+1 |
| ipi_in | input | 3*NUM_CORES | Per-core inter-processor interrupt value, 3 bits per core |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_core | input | CORE_W | Index of the requesting core |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| core_irq | output | NUM_CORES*(NUM_SRC+2) | Per-core interrupt lines; core c occupies bits [c*(NUM_SRC+2) +: NUM_SRC+2] |
| core_stall | output | NUM_CORES | Run-stall line per core |

## Verification
The hardest case to reach from the ports is a source that is routed and asserted by software while its enable bit is clear and its pin is low. This must be told apart from line 2, which source 0 and IPI bit 2 both drive. The bench drives the mask to a known pattern through the clear and set addresses first. It then asserts a mix of disabled, enabled and pin-less sources over non-trivial routing columns, and sweeps the external levels and the IPI values with that state held. It checks every line of every core against a model computed in the bench.

// File: rtl/irqdist_pkg.sv
// Shared constants of the interrupt distributor: register offsets and
// fixed field positions. Assumes a 10-bit offset space and 32-bit data.
package irqdist_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;
    localparam int IPI_W    = 3;
    localparam int ID_SHIFT = 18;

    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 10'h180;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 10'h184;
    localparam logic [ADDR_W-1:0] OFS_ASG_CLR = 10'h188;
    localparam logic [ADDR_W-1:0] OFS_ASG_SET = 10'h18C;
    localparam logic [ADDR_W-1:0] OFS_IDENT   = 10'h1A0;
    localparam logic [ADDR_W-1:0] OFS_STALL   = 10'h200;
    localparam logic [ADDR_W-1:0] OFS_CTL     = 10'h220;
endpackage

// File: rtl/irqdist_regs.sv
// Register file of the distributor: routing words, enable and software
// assert masks, run-stall and per-core control bits, plus read mux.
// Assumes NUM_SRC <= 32 so routing offsets stay below the mask offsets.
module irqdist_regs
    import irqdist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SRC   = 8,
    parameter int CORE_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_en,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic [CORE_W-1:0]            reg_core,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic [NUM_SRC-1:0]           en_q,
    output logic [NUM_SRC-1:0]           asg_q,
    output logic [NUM_SRC*NUM_CORES-1:0] route_flat,
    output logic [NUM_CORES-1:0]         stall_q
);
    logic                 wr_req;
    logic                 rd_req;
    logic [NUM_SRC-1:0]   wsrc;
    logic [NUM_CORES-1:0] wcore;
    logic [NUM_CORES-1:0] route_q [NUM_SRC];
    logic [NUM_CORES-1:0] ctl_q;
    logic [DATA_W-1:0]    rd_next;

    assign wr_req = reg_en && reg_we;
    assign rd_req = reg_en && !reg_we;
    assign wsrc   = reg_wdata[NUM_SRC-1:0];
    assign wcore  = reg_wdata[NUM_CORES-1:0];

    // Per-source routing words, reset to core 0 only
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[k] <= NUM_CORES'(1);
            else if (wr_req && reg_addr == ADDR_W'(k))
                route_q[k] <= wcore;
        end
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
            assign route_flat[k*NUM_CORES + c] = route_q[k][c];
        end
    end

    // Enable mask: clear and set addresses, all sources enabled at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '1;
        else if (wr_req && reg_addr == OFS_EN_CLR)
            en_q <= en_q & ~wsrc;
        else if (wr_req && reg_addr == OFS_EN_SET)
            en_q <= en_q | wsrc;
    end

    // Software-assert mask: clear and set addresses, empty at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            asg_q <= '0;
        else if (wr_req && reg_addr == OFS_ASG_CLR)
            asg_q <= asg_q & ~wsrc;
        else if (wr_req && reg_addr == OFS_ASG_SET)
            asg_q <= asg_q | wsrc;
    end

    // Run-stall register, every core but core 0 held at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall_q <= ~NUM_CORES'(1);
        else if (wr_req && reg_addr == OFS_STALL)
            stall_q <= wcore;
    end

    // Private control bit, written by the requesting core only
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[c] <= 1'b0;
            else if (wr_req && reg_addr == OFS_CTL && reg_core == CORE_W'(c))
                ctl_q[c] <= reg_wdata[0];
        end
    end

    // Read data selection for the current offset
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NUM_SRC; k++)
            if (reg_addr == ADDR_W'(k))
                rd_next = DATA_W'(route_q[k]);
        case (reg_addr)
            OFS_EN_CLR:  rd_next = DATA_W'(en_q);
            OFS_ASG_CLR: rd_next = DATA_W'(asg_q);
            OFS_IDENT:   rd_next = (DATA_W'(NUM_CORES - 1) << ID_SHIFT) | DATA_W'(reg_core);
            OFS_STALL:   rd_next = DATA_W'(stall_q);
            OFS_CTL: begin
                for (int c = 0; c < NUM_CORES; c++)
                    if (reg_core == CORE_W'(c))
                        rd_next = DATA_W'(ctl_q[c]);
            end
            default: ;
        endcase
    end

    // Registered read data, zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else
            reg_rdata <= rd_req ? rd_next : '0;
    end
endmodule

// File: rtl/irqdist_fanout.sv
// Per-core interrupt fan-out: forms the active source vector, masks it with
// each core's routing column, merges the IPI value and registers the result.
// Assumes the source level vector already holds 0 for the pin-less source 0.
module irqdist_fanout
    import irqdist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SRC   = 8,
    localparam int OUT_W    = NUM_SRC + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           src_level,
    input  logic [NUM_SRC-1:0]           en_q,
    input  logic [NUM_SRC-1:0]           asg_q,
    input  logic [NUM_SRC*NUM_CORES-1:0] route_flat,
    input  logic [IPI_W*NUM_CORES-1:0]   ipi_in,
    output logic [NUM_CORES*OUT_W-1:0]   core_irq
);
    logic [NUM_SRC-1:0] src_act;

    // Asserted sources bypass the enable mask
    assign src_act = (src_level & en_q) | asg_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_SRC-1:0] column;
        logic [OUT_W-1:0]   line_next;

        for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
            assign column[k] = route_flat[k*NUM_CORES + c];
        end

        // Shift routed sources up two lines and OR in the IPI value
        always_comb begin
            line_next = {src_act & column, 2'b00};
            line_next[IPI_W-1:0] = line_next[IPI_W-1:0] | ipi_in[c*IPI_W +: IPI_W];
        end

        // Output register for this core's lines
        always_ff @(posedge clk) begin
            if (!rst_n)
                core_irq[c*OUT_W +: OUT_W] <= '0;
            else
                core_irq[c*OUT_W +: OUT_W] <= line_next;
        end
    end
endmodule

// File: rtl/irqdist_top.sv
// Top of the multiprocessor interrupt distributor. Connects the register
// file to the per-core fan-out. Assumes 2 <= NUM_SRC <= 32 and
// 1 <= NUM_CORES <= 32.
module irqdist_top
    import irqdist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SRC   = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int OUT_W    = NUM_SRC + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-2:0]         ext_irq,
    input  logic [IPI_W*NUM_CORES-1:0] ipi_in,
    input  logic                       reg_en,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    input  logic [CORE_W-1:0]          reg_core,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_CORES*OUT_W-1:0] core_irq,
    output logic [NUM_CORES-1:0]       core_stall
);
    logic [NUM_SRC-1:0]           en_q;
    logic [NUM_SRC-1:0]           asg_q;
    logic [NUM_SRC*NUM_CORES-1:0] route_flat;
    logic [NUM_SRC-1:0]           src_level;

    // Source 0 has no pin; pins start at source 1
    assign src_level = {ext_irq, 1'b0};

    irqdist_regs #(
        .NUM_CORES(NUM_CORES),
        .NUM_SRC  (NUM_SRC),
        .CORE_W   (CORE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_core  (reg_core),
        .reg_rdata (reg_rdata),
        .en_q      (en_q),
        .asg_q     (asg_q),
        .route_flat(route_flat),
        .stall_q   (core_stall)
    );

    irqdist_fanout #(
        .NUM_CORES(NUM_CORES),
        .NUM_SRC  (NUM_SRC)
    ) u_fanout (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .en_q      (en_q),
        .asg_q     (asg_q),
        .route_flat(route_flat),
        .ipi_in    (ipi_in),
        .core_irq  (core_irq)
    );
endmodule

// File: rtl/irqdist_checker.sv
// Temporal checks on the distributor, attached to every irqdist_top.
module irqdist_checker
    import irqdist_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SRC   = 8,
    parameter int CORE_W    = 2,
    localparam int OUT_W    = NUM_SRC + 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SRC-2:0]           ext_irq,
    input logic [IPI_W*NUM_CORES-1:0]   ipi_in,
    input logic                         reg_en,
    input logic                         reg_we,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic [DATA_W-1:0]            reg_rdata,
    input logic [NUM_CORES*OUT_W-1:0]   core_irq,
    input logic [NUM_CORES-1:0]         core_stall,
    input logic [NUM_SRC-1:0]           en_q,
    input logic [NUM_SRC-1:0]           asg_q,
    input logic [NUM_SRC*NUM_CORES-1:0] route_flat
);
    // R3: cleared enable bits are zero after the write
    a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == OFS_EN_CLR)
        |=> ((en_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

    // R4: set assert bits are one after the write
    a_r4_assert_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == OFS_ASG_SET)
        |=> ((asg_q & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

    // R9: stall outputs follow the written value
    a_r9_stall_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == OFS_STALL)
        |=> (core_stall == $past(reg_wdata[NUM_CORES-1:0])));

    // R11: a hole in the offset map reads as zero
    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr >= 10'h1B0 && reg_addr < OFS_STALL)
        |=> (reg_rdata == '0));

    // R12: no read request means zero read data next cycle
    a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> (reg_rdata == '0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
        // R7: IPI bits always show up on the low lines
        a_r7_ipi_merge: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((core_irq[c*OUT_W +: IPI_W] & $past(ipi_in[c*IPI_W +: IPI_W]))
                      == $past(ipi_in[c*IPI_W +: IPI_W])));
        for (genvar k = 1; k < NUM_SRC; k++) begin : g_k
            // R2: a raised line needs an active and routed source
            a_r2_line_cause: assert property (@(posedge clk) disable iff (!rst_n)
                core_irq[c*OUT_W + k + 2]
                |-> $past(((ext_irq[k-1] && en_q[k]) || asg_q[k])
                          && route_flat[k*NUM_CORES + c]));
        end
    end
endmodule

bind irqdist_top irqdist_checker #(
    .NUM_CORES(NUM_CORES),
    .NUM_SRC  (NUM_SRC),
    .CORE_W   (CORE_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq   (ext_irq),
    .ipi_in    (ipi_in),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .core_irq  (core_irq),
    .core_stall(core_stall),
    .en_q      (en_q),
    .asg_q     (asg_q),
    .route_flat(route_flat)
);

// File: tb/tb_irqdist_top.sv
`timescale 1ns/1ps
module tb_irqdist_top;
    localparam int NC = 4;
    localparam int NS = 8;
    localparam int OW = NS + 2;
    localparam int CW = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-2:0]     ext_irq;
    logic [3*NC-1:0]   ipi_in;
    logic              reg_en, reg_we;
    logic [9:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [CW-1:0]     reg_core;
    logic [31:0]       reg_rdata;
    logic [NC*OW-1:0]  core_irq;
    logic [NC-1:0]     core_stall;

    always #4 clk = ~clk;

    irqdist_top #(.NUM_CORES(NC), .NUM_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .ipi_in(ipi_in),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_core(reg_core), .reg_rdata(reg_rdata),
        .core_irq(core_irq), .core_stall(core_stall)
    );

    // Bench model of the register state
    logic [NS-1:0] m_en, m_asg;
    logic [NC-1:0] m_route [NS];
    logic [NC-1:0] m_stall, m_ctl;
    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] rv;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] exp_core(int c);
        logic [OW-1:0] v = '0;
        for (int k = 0; k < NS; k++) begin
            logic lvl = (k == 0) ? 1'b0 : ext_irq[k-1];
            v[k+2] = ((lvl & m_en[k]) | m_asg[k]) & m_route[k][c];
        end
        v[2:0] = v[2:0] | ipi_in[c*3 +: 3];
        return v;
    endfunction

    task automatic chk_all(string tag);
        for (int c = 0; c < NC; c++)
            chk(tag, 32'(core_irq[c*OW +: OW]), 32'(exp_core(c)));
        chk(tag, 32'(core_stall), 32'(m_stall));
    endtask

    // Write at a negedge; registers take it at the next posedge
    task automatic wr(logic [9:0] a, logic [31:0] d, int core = 0);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_core = CW'(core);
        @(negedge clk);
        reg_en = 0; reg_we = 0;
        case (a)
            10'h180: m_en  = m_en  & ~d[NS-1:0];
            10'h184: m_en  = m_en  |  d[NS-1:0];
            10'h188: m_asg = m_asg & ~d[NS-1:0];
            10'h18C: m_asg = m_asg |  d[NS-1:0];
            10'h200: m_stall = d[NC-1:0];
            10'h220: m_ctl[core] = d[0];
            default: if (a < NS) m_route[a] = d[NC-1:0];
        endcase
    endtask

    task automatic rd(logic [9:0] a, int core, output logic [31:0] d);
        reg_en = 1; reg_we = 0; reg_addr = a; reg_core = CW'(core);
        @(negedge clk);
        reg_en = 0;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic chk_regs(string tag);
        rd(10'h180, 0, rv); chk(tag, rv, 32'(m_en));
        rd(10'h188, 0, rv); chk(tag, rv, 32'(m_asg));
        rd(10'h200, 0, rv); chk(tag, rv, 32'(m_stall));
        for (int k = 0; k < NS; k++) begin
            rd(10'(k), 0, rv); chk(tag, rv, 32'(m_route[k]));
        end
        for (int c = 0; c < NC; c++) begin
            rd(10'h220, c, rv); chk(tag, rv, 32'(m_ctl[c]));
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ext_irq = '0; ipi_in = '0;
        reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0; reg_core = '0;
        m_en = '1; m_asg = '0; m_stall = ~NC'(1); m_ctl = '0;
        for (int k = 0; k < NS; k++) m_route[k] = NC'(1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();

        // R1: reset state of outputs and every register
        chk_all("R1");
        chk_regs("R1");

        // R8: identification word per requesting core
        for (int c = 0; c < NC; c++) begin
            rd(10'h1A0, c, rv); chk("R8", rv, (32'(NC - 1) << 18) | 32'(c));
        end

        // R2/R6: sweep every external pattern with reset routing
        for (int p = 0; p < (1 << (NS - 1)); p++) begin
            ext_irq = (NS-1)'(p); settle(); chk_all("R2");
        end
        ext_irq = '1; settle();
        chk("R6", 32'(core_irq[2]), 32'd0);   // source 0 has no pin

        // R5: distinct routing columns, read back, sweep
        for (int k = 0; k < NS; k++) wr(10'(k), 32'hFFFF_FFF0 | 32'((k * 5 + 3) & 4'hF));
        for (int k = 0; k < NS; k++) begin
            rd(10'(k), 1, rv); chk("R5", rv, 32'((k * 5 + 3) & 4'hF));
        end
        for (int p = 0; p < (1 << (NS - 1)); p += 3) begin
            ext_irq = (NS-1)'(p); settle(); chk_all("R5");
        end

        // R3: clear then set enable bits, sweep in between
        wr(10'h180, 32'h55); settle();
        rd(10'h180, 2, rv); chk("R3", rv, 32'hAA);
        for (int p = 0; p < (1 << (NS - 1)); p += 5) begin
            ext_irq = (NS-1)'(p); settle(); chk_all("R3");
        end
        wr(10'h184, 32'h05); settle();
        rd(10'h180, 0, rv); chk("R3", rv, 32'hAF);
        chk_all("R3");

        // R4: asserted sources bypass the enable mask, incl. pin-less source 0
        ext_irq = '0;
        wr(10'h18C, 32'h51); settle();
        rd(10'h188, 0, rv); chk("R4", rv, 32'h51);
        for (int p = 0; p < (1 << (NS - 1)); p += 7) begin
            ext_irq = (NS-1)'(p); settle(); chk_all("R4");
        end
        wr(10'h188, 32'h11); settle();
        rd(10'h188, 0, rv); chk("R4", rv, 32'h40);
        chk_all("R4");

        // R7: every IPI value on every core, with source 0 also routed
        wr(10'h18C, 32'h01); settle();
        for (int c = 0; c < NC; c++)
            for (int v = 0; v < 8; v++) begin
                ipi_in = '0; ipi_in[c*3 +: 3] = 3'(v); settle(); chk_all("R7");
            end
        ipi_in = 12'hA5C; settle(); chk_all("R7");
        ipi_in = '0;

        // R9: run-stall write, output and read back
        wr(10'h200, 32'hFFFF_FFF5);
        chk("R9", 32'(core_stall), 32'h5);
        rd(10'h200, 3, rv); chk("R9", rv, 32'h5);
        wr(10'h200, 32'h0);
        chk("R9", 32'(core_stall), 32'h0);

        // R10: private control bit per core, only bit 0 kept
        for (int c = 0; c < NC; c++) wr(10'h220, 32'hFFFF_FFFE | 32'(c & 1), c);
        for (int c = 0; c < NC; c++) begin
            rd(10'h220, c, rv); chk("R10", rv, 32'(c & 1));
        end

        // R11: writes to holes change nothing; holes read zero
        ext_irq = 7'h5A; settle(); settle();
        wr(10'h1B0, 32'hFFFF_FFFF); wr(10'h300, 32'hFFFF_FFFF);
        wr(10'(NS), 32'hFFFF_FFFF); wr(10'h3FC, 32'h0);
        settle();
        chk_all("R11");
        chk_regs("R11");
        rd(10'h184, 0, rv); chk("R11", rv, 32'h0);
        rd(10'h18C, 0, rv); chk("R11", rv, 32'h0);
        rd(10'h1B0, 0, rv); chk("R11", rv, 32'h0);
        rd(10'(NS), 0, rv); chk("R11", rv, 32'h0);

        // R12: read data lasts one cycle only
        rd(10'h180, 0, rv); chk("R12", rv, 32'(m_en));
        settle(); chk("R12", reg_rdata, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule